// File: doc/BRIEF.md
# Segment-Interpolated Function Table

This block produces values of a fixed function from a short table of coarse samples. The table is held as a constant ROM inside the design and is computed from a quadratic curve at elaboration. Between two stored neighbours the block fills in values by linear interpolation. The only arithmetic it uses is arithmetic right shifts and additions, with no multiplier.

The input position carries two fields. The upper `IDX_W` bits, `in_pos[POS_W-1:FRAC_W]`, pick a segment index k. The lower `FRAC_W` bits, `in_pos[FRAC_W-1:0]`, pick one of 2^FRAC_W equal sub-steps f inside that segment.

The block has two modes:
- **Direct mode** (`mode_step` low): the block returns one interpolated value for each accepted position.
- **Stepping mode** (`mode_step` high): the block loads a starting position and then walks forward one sub-step per clock. At each sub-step it adds a pre-shifted slope to a running value. At each segment boundary it reloads the running value exactly from the next stored sample.

With default parameters the stored samples are y(k) = 37·k·(11−k) − 900 for k = 0..11. The index field is 4 bits wide and the fraction field is 3 bits wide, so each segment has 8 sub-steps. The curve therefore has rising segments, one flat segment (k = 5 to 6) and falling segments.

Top module: `lut_interp`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 until a position is accepted.
- R2: A position accepted with `in_valid`=1 and `mode_step`=0 gives `out_valid`=1 exactly one clock later. `out_val` then equals y(k) + floor((y(k+1) − y(k))·f / 2^FRAC_W), where k = `in_pos[6:3]` and f = `in_pos[2:0]`. If no new input follows, `out_valid` is 0 the clock after.
- R3: In direct mode, a position with f = 0 returns the stored sample y(k) exactly.
- R4: The slope is signed. Falling segments round toward minus infinity, as the formula in R2 states.
- R5: A position accepted with `mode_step`=1 gives, one clock later, y(k) + f·floor((y(k+1) − y(k)) / 2^FRAC_W).
- R6: While `mode_step` stays 1 and no new input arrives, each clock advances f by one. `out_val` then grows by floor((y(k+1) − y(k)) / 2^FRAC_W) and `out_valid` stays 1.
- R7: When stepping passes f = 2^FRAC_W − 1, the next output is exactly y(k+1). Interpolation then continues on the pair y(k+1), y(k+2).
- R8: Every index at or beyond the last stored entry (k ≥ 11) behaves as a flat segment holding y(11), in both modes. Stepping into that region keeps returning y(11).
- R9: Dropping `mode_step` with no new input ends stepping, and `out_valid` is 0 the next clock.
- R10: A new accepted position during stepping takes effect at once. It restarts the block from that position in the mode given by `mode_step` at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_step | input | 1 | 1 = stepping mode, 0 = direct mode |
| in_valid | input | 1 | Accept `in_pos` this clock |
| in_pos | input | IDX_W+FRAC_W | Segment index (upper bits) and sub-step (lower bits) |
| out_valid | output | 1 | `out_val` holds a result |
| out_val | output | DATA_W | Interpolated value, two's complement |

## Verification
The hardest condition to reach is a stepping walk that crosses segment boundaries. On such a walk the accumulated value, which carries floor rounding, must be dropped in favour of the exact next sample. The walk must then run into the clamped end of the table.

The bench reaches this by starting a stepping run part-way through segment 9 and holding `mode_step` for thirty clocks. That run crosses two boundaries, including a falling segment with a non-exact slope, and then cycles inside the clamped region. A second run is cut short by a direct-mode load, to cover the restart rule.

// File: rtl/lut_interp_pkg.sv
// Package lut_interp_pkg
// Shared helpers for the interpolating function table.
// Assumes: sample values fit in 32-bit signed integer arithmetic.
package lut_interp_pkg;

    // Stored curve: gain * k * (last - k) + offset, an arch with a flat top.
    function automatic int curve_sample(input int k, input int n_pts,
                                        input int gain, input int offs);
        return gain * k * (n_pts - 1 - k) + offs;
    endfunction

endpackage

// File: rtl/interp_rom_pair.sv
// Module interp_rom_pair
// Constant sample ROM returning the sample at an index and its right-hand
// neighbour. Indices at or past the last entry read the last entry for both.
// Assumes: 2 <= NUM_PTS <= 2**IDX_W; purely combinational.
module interp_rom_pair
    import lut_interp_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int NUM_PTS = 12,
    parameter int DATA_W  = 16,
    parameter int GAIN    = 37,
    parameter int OFFS    = -900
) (
    input  logic [IDX_W-1:0]         idx,
    output logic signed [DATA_W-1:0] y_lo,
    output logic signed [DATA_W-1:0] y_hi
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PTS - 1);

    logic signed [DATA_W-1:0] rom_tbl [NUM_PTS];
    logic [IDX_W-1:0]         lo_idx;
    logic [IDX_W-1:0]         hi_idx;

    // Build the constant table entry by entry.
    for (genvar i = 0; i < NUM_PTS; i++) begin : g_entry
        assign rom_tbl[i] = DATA_W'(curve_sample(i, NUM_PTS, GAIN, OFFS));
    end

    // Clamp both read indices to the last stored entry.
    always_comb begin
        lo_idx = (idx >= LAST_IDX) ? LAST_IDX : idx;
        hi_idx = (lo_idx == LAST_IDX) ? LAST_IDX : lo_idx + 1'b1;
    end

    // Read the pair.
    always_comb begin
        y_lo = rom_tbl[lo_idx];
        y_hi = rom_tbl[hi_idx];
    end
endmodule

// File: rtl/shift_add_scale.sv
// Module shift_add_scale
// Multiplies a signed operand by a small unsigned factor using only shifted
// copies and additions, one partial term per factor bit.
// Assumes: the result width IN_W+FRAC_W holds the full product.
module shift_add_scale #(
    parameter int IN_W   = 17,
    parameter int FRAC_W = 3
) (
    input  logic signed [IN_W-1:0]        operand,
    input  logic [FRAC_W-1:0]             factor,
    output logic signed [IN_W+FRAC_W-1:0] product
);
    localparam int PROD_W = IN_W + FRAC_W;

    logic signed [PROD_W-1:0] ext_op;
    logic signed [PROD_W-1:0] partial [FRAC_W];

    assign ext_op = PROD_W'(operand);

    // One gated, shifted copy of the operand per factor bit.
    for (genvar b = 0; b < FRAC_W; b++) begin : g_term
        assign partial[b] = factor[b] ? (ext_op <<< b) : '0;
    end

    // Sum the partial terms.
    always_comb begin
        product = '0;
        for (int b = 0; b < FRAC_W; b++) begin
            product = product + partial[b];
        end
    end
endmodule

// File: rtl/lut_interp.sv
// Module lut_interp
// Interpolating function table: direct evaluation of one position, or
// per-clock stepping through sub-intervals with exact reload at each
// segment boundary. One clock from accepted input to valid output.
// Assumes: synchronous active-low reset; stored values leave two bits of
// headroom in DATA_W so the running value never overflows.
module lut_interp
    import lut_interp_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int FRAC_W  = 3,
    parameter int NUM_PTS = 12,
    parameter int DATA_W  = 16,
    parameter int GAIN    = 37,
    parameter int OFFS    = -900
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_step,
    input  logic                        in_valid,
    input  logic [IDX_W+FRAC_W-1:0]     in_pos,
    output logic                        out_valid,
    output logic signed [DATA_W-1:0]    out_val
);
    localparam int POS_W  = IDX_W + FRAC_W;
    localparam int DIFF_W = DATA_W + 1;
    localparam int PROD_W = DIFF_W + FRAC_W;
    localparam int ACC_W  = DATA_W + 2;
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_PTS - 1);

    // Input fields.
    logic [IDX_W-1:0]  in_idx;
    logic [FRAC_W-1:0] in_frac;

    // ROM read for a new position.
    logic signed [DATA_W-1:0] rin_lo, rin_hi;
    logic signed [DIFF_W-1:0] rin_diff, rin_step;
    logic signed [PROD_W-1:0] start_prod;
    logic signed [ACC_W-1:0]  start_run;

    // Registered state.
    logic                     vld_q, step_q;
    logic [IDX_W-1:0]         idx_q;
    logic [FRAC_W-1:0]        frac_q;
    logic signed [DATA_W-1:0] base_q, next_q;
    logic signed [ACC_W-1:0]  run_q;

    // Derived from state.
    logic signed [DIFF_W-1:0] q_diff, q_step;
    logic signed [PROD_W-1:0] dir_prod;
    logic signed [ACC_W-1:0]  dir_val;
    logic [IDX_W-1:0]         adv_idx;
    logic signed [DATA_W-1:0] radv_lo, radv_hi;
    logic                     advancing;

    assign in_idx  = in_pos[POS_W-1:FRAC_W];
    assign in_frac = in_pos[FRAC_W-1:0];

    interp_rom_pair #(
        .IDX_W(IDX_W), .NUM_PTS(NUM_PTS), .DATA_W(DATA_W),
        .GAIN(GAIN), .OFFS(OFFS)
    ) u_rom_in (
        .idx(in_idx), .y_lo(rin_lo), .y_hi(rin_hi)
    );

    // Slope of the addressed segment and its per-sub-step share.
    always_comb begin
        rin_diff = DIFF_W'(rin_hi) - DIFF_W'(rin_lo);
        rin_step = rin_diff >>> FRAC_W;
    end

    shift_add_scale #(.IN_W(DIFF_W), .FRAC_W(FRAC_W)) u_start_scale (
        .operand(rin_step), .factor(in_frac), .product(start_prod)
    );

    // Running value that stepping would have reached at the start position.
    assign start_run = ACC_W'(rin_lo) + ACC_W'(start_prod);

    // Slope of the registered segment.
    always_comb begin
        q_diff = DIFF_W'(next_q) - DIFF_W'(base_q);
        q_step = q_diff >>> FRAC_W;
    end

    shift_add_scale #(.IN_W(DIFF_W), .FRAC_W(FRAC_W)) u_direct_scale (
        .operand(q_diff), .factor(frac_q), .product(dir_prod)
    );

    // Direct value: base plus scaled difference, shifted down once.
    assign dir_val = ACC_W'(base_q) + ACC_W'(dir_prod >>> FRAC_W);

    // Next segment index, held once the end of the table is reached.
    assign adv_idx = (idx_q >= LAST_IDX) ? idx_q : idx_q + 1'b1;

    interp_rom_pair #(
        .IDX_W(IDX_W), .NUM_PTS(NUM_PTS), .DATA_W(DATA_W),
        .GAIN(GAIN), .OFFS(OFFS)
    ) u_rom_adv (
        .idx(adv_idx), .y_lo(radv_lo), .y_hi(radv_hi)
    );

    assign advancing = !in_valid && step_q && mode_step;

    // Load, step, or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            step_q <= 1'b0;
            idx_q  <= '0;
            frac_q <= '0;
            base_q <= '0;
            next_q <= '0;
            run_q  <= '0;
        end else if (in_valid) begin
            vld_q  <= 1'b1;
            step_q <= mode_step;
            idx_q  <= in_idx;
            frac_q <= in_frac;
            base_q <= rin_lo;
            next_q <= rin_hi;
            run_q  <= start_run;
        end else if (advancing) begin
            if (frac_q == FRAC_MAX) begin
                idx_q  <= adv_idx;
                frac_q <= '0;
                base_q <= radv_lo;
                next_q <= radv_hi;
                run_q  <= ACC_W'(radv_lo);
            end else begin
                frac_q <= frac_q + 1'b1;
                run_q  <= run_q + ACC_W'(q_step);
            end
        end else begin
            vld_q  <= 1'b0;
            step_q <= 1'b0;
        end
    end

    // Output select by mode.
    assign out_valid = vld_q;
    assign out_val   = step_q ? DATA_W'(run_q) : DATA_W'(dir_val);

    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !(step_q && mode_step)) |=> !out_valid); // R9
    AST_WRAP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (advancing && frac_q == FRAC_MAX) |=> (out_val == $past(next_q))); // R7
    AST_CLAMP_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && idx_q >= LAST_IDX) |-> (base_q == next_q)); // R8
    AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !step_q && frac_q == '0) |-> (out_val == base_q)); // R3
endmodule

// File: tb/lut_interp_tb.sv
module lut_interp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_step = 1'b0;
    logic       in_valid = 1'b0;
    logic [6:0] in_pos = '0;
    logic       out_valid;
    logic signed [15:0] out_val;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lut_interp u_dut (
        .clk(clk), .rst_n(rst_n), .mode_step(mode_step),
        .in_valid(in_valid), .in_pos(in_pos),
        .out_valid(out_valid), .out_val(out_val)
    );

    // Stimulus table: {segment, sub-step} for direct-mode checks.
    localparam logic [6:0] VEC_POS [12] = '{
        {4'd0, 3'd0}, {4'd0, 3'd5}, {4'd1, 3'd3}, {4'd3, 3'd7},
        {4'd5, 3'd4}, {4'd6, 3'd2}, {4'd7, 3'd1}, {4'd8, 3'd6},
        {4'd10, 3'd7}, {4'd11, 3'd0}, {4'd11, 3'd5}, {4'd15, 3'd7}
    };

    function automatic int ys(input int k);
        int kk = (k > 11) ? 11 : k;
        return 37 * kk * (11 - kk) - 900;
    endfunction

    function automatic int direct_ref(input int k, input int f);
        return ys(k) + (((ys(k + 1) - ys(k)) * f) >>> 3);
    endfunction

    function automatic int step_ref(input int k, input int f);
        return ys(k) + f * ((ys(k + 1) - ys(k)) >>> 3);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_direct(input int k, input int f, input string tag);
        @(negedge clk);
        in_valid = 1'b1; mode_step = 1'b0; in_pos = {4'(k), 3'(f)};
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, int'(out_valid), 1);
        check({tag, " value"}, int'(out_val), direct_ref(k, f));
        @(negedge clk);
        check({tag, " drop"}, int'(out_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k, f;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(out_valid), 0);

        // R2: table walk in direct mode.
        for (int i = 0; i < 12; i++) begin
            run_direct(int'(VEC_POS[i][6:3]), int'(VEC_POS[i][2:0]), "R2");
        end

        // R3 exact sample, R4 falling segment with inexact slope, R8 clamp.
        run_direct(7, 0, "R3");
        run_direct(7, 3, "R4");
        run_direct(9, 5, "R4");
        run_direct(13, 2, "R8");
        run_direct(12, 0, "R8");

        // R5..R8: stepping across two boundaries into the clamped tail.
        k = 9; f = 5;
        @(negedge clk);
        in_valid = 1'b1; mode_step = 1'b1; in_pos = {4'(k), 3'(f)};
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 start valid", int'(out_valid), 1);
        check("R5 start value", int'(out_val), step_ref(k, f));
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (f == 7) begin
                f = 0;
                if (k < 11) k++;
            end else begin
                f++;
            end
            check("R6 step valid", int'(out_valid), 1);
            if (k >= 11)
                check("R8 step clamp", int'(out_val), ys(11));
            else if (f == 0)
                check("R7 wrap exact", int'(out_val), ys(k));
            else
                check("R6 step value", int'(out_val), step_ref(k, f));
        end

        // R9: release stepping.
        mode_step = 1'b0;
        @(negedge clk);
        check("R9 stop", int'(out_valid), 0);

        // R10: restart during stepping with a direct-mode load.
        k = 2; f = 1;
        @(negedge clk);
        in_valid = 1'b1; mode_step = 1'b1; in_pos = {4'(k), 3'(f)};
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 step start", int'(out_val), step_ref(k, f));
        repeat (3) @(negedge clk);
        check("R10 step running", int'(out_val), step_ref(2, 4));
        in_valid = 1'b1; mode_step = 1'b0; in_pos = {4'd4, 3'd3};
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 restart valid", int'(out_valid), 1);
        check("R10 restart value", int'(out_val), direct_ref(4, 3));
        @(negedge clk);
        check("R10 restart drop", int'(out_valid), 0);

        // R1: reset in the middle of stepping clears the output.
        in_valid = 1'b1; mode_step = 1'b1; in_pos = {4'd1, 3'd0};
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", int'(out_valid), 0);
        rst_n = 1'b1;
        mode_step = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule